// File: doc/BRIEF.md
# Bitstream Decimation Accumulator

This block counts the ones in a high-rate single-bit comparator stream and hands the count to a processor as a 16-bit result. Four comparator bitstreams arrive from analog columns. A control field picks one of them, and the block adds one to an internal accumulator on each system clock in which that bit is high. Slower filtering of the results is done in software, outside this block.

A latch strobe marks the end of each decimation window. Two timer-style strobes come into the block, and a control bit picks which one acts as the latch. On the rising edge of the chosen strobe, the accumulator value is copied into a readable result register, and the accumulator starts again from zero. For incremental conversions, each column has a gate enable. When the enable of the selected column is set, the comparator bit counts only while a chosen gate strobe is high.

A byte-wide register bus gives access to the high result byte, the low result byte and the control register. A write to the high-byte address clears the whole result.

Top module: `dec_accum_top`

## Requirements
- R1: After a synchronous reset, the result bytes, the control register and the accumulator are all zero. Reads of addresses 0, 1 and 2 return 0.
- R2: A write to address 2 loads the control register, and a read of address 2 returns it. Its layout is: bit 0 = latch source, bits 2:1 = comparator select, bit 3 = gate source, bits 7:4 = gate enables for columns 3..0 (bit 4 is column 0). A source bit of 0 selects `strobe_a` and 1 selects `strobe_b`.
- R3: The comparator select value k (0..3) makes `cmp_bits[k]` the counted stream. The other comparator bits have no effect on the count.
- R4: On each clock in which the selected comparator bit is high, is not gated and no latch edge occurs, the accumulator increases by exactly 1.
- R5: When the gate enable of the selected column is set, the comparator bit counts only in clocks where the strobe chosen by the gate source bit is high. Gate enables of unselected columns have no effect.
- R6: A clock in which the selected latch strobe is high after being low in the previous clock copies the accumulator into the result and reloads the accumulator with zero. Holding the strobe high does not capture again, and edges on the unselected strobe do nothing.
- R7: The accumulator saturates at 16'hFFFF and does not wrap.
- R8: A write of any value to address 0 clears the 16-bit result. If it coincides with a latch edge, the result is 0, and the accumulator still restarts from zero.
- R9: Writes to address 1 and address 3 have no effect. Address 3 reads 0.
- R10: `bus_rdata` is registered. It shows the data for the address presented in the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_bits | input | 4 | Comparator bitstreams, one per column |
| strobe_a | input | 1 | Timer strobe A (latch or gate source 0) |
| strobe_b | input | 1 | Timer strobe B (latch or gate source 1) |
| bus_addr | input | 2 | Register address: 0 result high, 1 result low, 2 control |
| bus_wr | input | 1 | Write enable for one clock |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The bench aims at the following corner cases, and at what a wrong design would show for each:
- **Saturation.** The selected comparator bit is held high for more than 65535 clocks. A wrapping counter would return a small value instead of 16'hFFFF.
- **Clear against latch.** A clear write and a latch edge land in the same clock. A design that gives the capture priority would show a non-zero result.
- **Held latch strobe.** The latch strobe is held high while counting goes on. A level-sensitive latch would keep recapturing, so the value read back would change.
- **Gate source.** Gating is tried with the selected column gated and ungated, and with only an unselected column gated. A design that decodes the gate enable or the gate source wrongly would count when it should stay at zero, or the reverse.

// File: rtl/dec_accum_pkg.sv
package dec_accum_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_DHI  = 2'd0,
    ADDR_DLO  = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/dec_strobe_edge.sv
module dec_strobe_edge #(
  parameter int N_STROBE = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_STROBE-1:0] strobe_in,
  output logic [N_STROBE-1:0] rise
);
  logic [N_STROBE-1:0] prev_q;

  for (genvar i = 0; i < N_STROBE; i++) begin : g_edge
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= 1'b0;
      else     prev_q[i] <= strobe_in[i];
    end
    assign rise[i] = strobe_in[i] & ~prev_q[i];

    // R6: a strobe cannot show a rising edge in two consecutive clocks
    a_r6_single_rise: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> !rise[i]);
  end
endmodule

// File: rtl/dec_regfile.sv
module dec_regfile
  import dec_accum_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTRL_W = 8,
  parameter int RES_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [RES_W-1:0]  result,
  output logic [CTRL_W-1:0] ctrl,
  output logic              clr_result,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [DATA_W-1:0] rdata_d;

  assign clr_result = bus_wr && (bus_addr == ADDR_DHI);

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (bus_wr && bus_addr == ADDR_CTRL) ctrl <= bus_wdata[CTRL_W-1:0];
  end

  always_comb begin
    rdata_d = '0;
    case (bus_addr)
      ADDR_DHI:  rdata_d = result[RES_W-1 -: DATA_W];
      ADDR_DLO:  rdata_d = result[DATA_W-1:0];
      ADDR_CTRL: rdata_d[CTRL_W-1:0] = ctrl;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rdata_d;
  end

  // R2: a control write is visible in the register on the next clock
  a_r2_ctrl_load: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_CTRL) |=> ctrl == $past(bus_wdata[CTRL_W-1:0]));
  // R9: writes to other addresses leave the control register alone
  a_r9_ctrl_keep: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == ADDR_CTRL) |=> $stable(ctrl));
  // R9: the unused address always reads zero
  a_r9_hole_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_NONE) |=> bus_rdata == '0);
endmodule

// File: rtl/dec_accum_core.sv
module dec_accum_core #(
  parameter int N_COL = 4,
  parameter int ACC_W = 16,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_COL-1:0]  cmp_bits,
  input  logic [1:0]        strobe_lvl,
  input  logic [1:0]        strobe_rise,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              clr_result,
  output logic [ACC_W-1:0]  result
);
  localparam int SEL_W = $clog2(N_COL);
  localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

  logic             latch_src, gate_src;
  logic [SEL_W-1:0] cmp_sel;
  logic [N_COL-1:0] gate_en;
  logic             cmp_bit, gate_lvl, gated, cnt_en, latch_rise;
  logic [ACC_W-1:0] acc_q;

  assign latch_src = ctrl[0];
  assign cmp_sel   = ctrl[SEL_W:1];
  assign gate_src  = ctrl[SEL_W+1];
  assign gate_en   = ctrl[CTRL_W-1 -: N_COL];

  assign cmp_bit    = cmp_bits[cmp_sel];
  assign gate_lvl   = gate_src ? strobe_lvl[1] : strobe_lvl[0];
  assign gated      = gate_en[cmp_sel] & ~gate_lvl;
  assign cnt_en     = cmp_bit & ~gated;
  assign latch_rise = latch_src ? strobe_rise[1] : strobe_rise[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (latch_rise) begin
      acc_q <= '0;
    end else if (cnt_en && acc_q != ACC_MAX) begin
      acc_q <= acc_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             result <= '0;
    else if (clr_result) result <= '0;
    else if (latch_rise) result <= acc_q;
  end

  // R4: an enabled count below the top advances by one
  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !latch_rise && acc_q != ACC_MAX) |=> acc_q == $past(acc_q) + 1'b1);
  // R4/R5: without a count enable the accumulator holds
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !latch_rise) |=> $stable(acc_q));
  // R7: a full accumulator stays full until a latch
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (acc_q == ACC_MAX && !latch_rise) |=> acc_q == ACC_MAX);
  // R6: a latch edge restarts the accumulator and captures it
  a_r6_restart: assert property (@(posedge clk) disable iff (rst)
    latch_rise |=> acc_q == '0);
  a_r6_capture: assert property (@(posedge clk) disable iff (rst)
    (latch_rise && !clr_result) |=> result == $past(acc_q));
  // R8: a clear write empties the result, even against a latch edge
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    clr_result |=> result == '0);
  // R6: with no latch and no clear the result is steady
  a_r6_result_keep: assert property (@(posedge clk) disable iff (rst)
    (!latch_rise && !clr_result) |=> $stable(result));
endmodule

// File: rtl/dec_accum_top.sv
module dec_accum_top
  import dec_accum_pkg::*;
#(
  parameter int N_COL  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_COL-1:0]  cmp_bits,
  input  logic              strobe_a,
  input  logic              strobe_b,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int ACC_W  = 2 * DATA_W;
  localparam int SEL_W  = $clog2(N_COL);
  localparam int CTRL_W = N_COL + SEL_W + 2;

  logic [1:0]        strobes, rises;
  logic [CTRL_W-1:0] ctrl;
  logic              clr_result;
  logic [ACC_W-1:0]  result;

  assign strobes = {strobe_b, strobe_a};

  dec_strobe_edge #(.N_STROBE(2)) i_edge (
    .clk(clk), .rst(rst), .strobe_in(strobes), .rise(rises)
  );

  dec_regfile #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .RES_W(ACC_W)) i_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .result(result), .ctrl(ctrl),
    .clr_result(clr_result), .bus_rdata(bus_rdata)
  );

  dec_accum_core #(.N_COL(N_COL), .ACC_W(ACC_W), .CTRL_W(CTRL_W)) i_core (
    .clk(clk), .rst(rst), .cmp_bits(cmp_bits), .strobe_lvl(strobes),
    .strobe_rise(rises), .ctrl(ctrl), .clr_result(clr_result), .result(result)
  );
endmodule

// File: tb/test_dec_accum_top.sv
module test_dec_accum_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cmp_bits = '0;
  logic       strobe_a = 1'b0, strobe_b = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  int n_checks = 0, n_fail = 0;

  always #10 clk = ~clk;

  dec_accum_top i_dec_accum_top (
    .clk(clk), .rst(rst), .cmp_bits(cmp_bits), .strobe_a(strobe_a),
    .strobe_b(strobe_b), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [3:0]  cmp;
    logic        lva;
    logic        lvb;
    logic [7:0]  n;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h00, 4'b0001, 1'b0, 1'b0, 8'd10, 16'd10}, // R3 R4 column 0, latch A
    '{8'h00, 4'b1110, 1'b0, 1'b0, 8'd7,  16'd0},  // R3 others ignored
    '{8'h04, 4'b0100, 1'b0, 1'b0, 8'd13, 16'd13}, // R3 column 2
    '{8'h07, 4'b1000, 1'b0, 1'b0, 8'd5,  16'd5},  // R3 R6 column 3, latch B
    '{8'h23, 4'b0010, 1'b0, 1'b0, 8'd9,  16'd0},  // R5 gated, gate A low
    '{8'h23, 4'b0010, 1'b1, 1'b0, 8'd9,  16'd9},  // R5 gate A high passes
    '{8'h2A, 4'b0010, 1'b0, 1'b1, 8'd6,  16'd6},  // R5 gate source B high
    '{8'h13, 4'b0010, 1'b0, 1'b0, 8'd9,  16'd9}   // R5 other column's gate ignored
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic read_result(output logic [15:0] r);
    logic [7:0] hi, lo;
    bus_read(2'd0, hi);
    bus_read(2'd1, lo);
    r = {hi, lo};
  endtask

  task automatic pulse_latch(input logic use_b);
    @(negedge clk);
    if (use_b) strobe_b = 1'b1; else strobe_a = 1'b1;
    @(negedge clk);
    strobe_a = 1'b0; strobe_b = 1'b0;
  endtask

  task automatic count_run(input logic [3:0] pat, input int n);
    @(negedge clk);
    cmp_bits = pat;
    repeat (n) @(posedge clk);
    @(negedge clk);
    cmp_bits = '0;
  endtask

  initial begin
    logic [7:0]  d;
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    read_result(r);   check("R1 result", r, 16'h0000);
    bus_read(2'd2, d); check("R1 ctrl", {8'h00, d}, 16'h0000);

    // R2 control readback
    bus_write(2'd2, 8'hA5);
    bus_read(2'd2, d); check("R2 ctrl readback", {8'h00, d}, 16'h00A5);

    // R10 latency: address change is not visible until the next clock
    @(negedge clk); bus_addr = 2'd0;
    #5; check("R10 old data held", {8'h00, bus_rdata}, 16'h00A5);
    @(negedge clk); check("R10 new data", {8'h00, bus_rdata}, 16'h0000);

    // vector table
    for (int i = 0; i < 8; i++) begin
      bus_write(2'd2, VECS[i].ctrl);
      pulse_latch(VECS[i].ctrl[0]);
      @(negedge clk);
      cmp_bits = VECS[i].cmp; strobe_a = VECS[i].lva; strobe_b = VECS[i].lvb;
      repeat (int'(VECS[i].n)) @(posedge clk);
      @(negedge clk);
      cmp_bits = '0; strobe_a = 1'b0; strobe_b = 1'b0;
      pulse_latch(VECS[i].ctrl[0]);
      read_result(r);
      check($sformatf("R3/R4/R5 vector %0d", i), r, VECS[i].exp);
    end

    // R6 restart: second window holds only its own count
    bus_write(2'd2, 8'h00);
    pulse_latch(1'b0);
    count_run(4'b0001, 20);
    pulse_latch(1'b0);
    count_run(4'b0001, 4);
    pulse_latch(1'b0);
    read_result(r); check("R6 restart from zero", r, 16'd4);

    // R6 held strobe: captures once only
    count_run(4'b0001, 11);
    @(negedge clk); strobe_a = 1'b1;
    count_run(4'b0001, 8);
    read_result(r); check("R6 held strobe no recapture", r, 16'd11);
    @(negedge clk); strobe_a = 1'b0;
    // R6 unselected strobe B edge does nothing
    pulse_latch(1'b1);
    read_result(r); check("R6 unselected strobe ignored", r, 16'd11);
    pulse_latch(1'b0);
    read_result(r); check("R6 restart after held strobe", r, 16'd8);

    // R9 writes to the low byte and the unused address are ignored
    bus_write(2'd1, 8'hFF);
    bus_write(2'd3, 8'hFF);
    read_result(r); check("R9 low byte read-only", r, 16'd8);
    bus_read(2'd3, d); check("R9 hole reads zero", {8'h00, d}, 16'h0000);
    bus_read(2'd2, d); check("R9 ctrl untouched", {8'h00, d}, 16'h0000);

    // R8 clear by write
    bus_write(2'd0, 8'h5A);
    read_result(r); check("R8 clear", r, 16'h0000);

    // R8 clear and latch in the same clock
    count_run(4'b0001, 6);
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 8'h01; bus_wr = 1'b1; strobe_a = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; strobe_a = 1'b0;
    read_result(r); check("R8 clear wins over latch", r, 16'h0000);
    pulse_latch(1'b0);
    read_result(r); check("R8 accumulator restarted", r, 16'h0000);

    // R7 saturation
    count_run(4'b0001, 65545);
    pulse_latch(1'b0);
    read_result(r); check("R7 saturate", r, 16'hFFFF);

    // R1 reset again clears everything
    bus_write(2'd2, 8'h3C);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    read_result(r); check("R1 reset result", r, 16'h0000);
    bus_read(2'd2, d); check("R1 reset ctrl", {8'h00, d}, 16'h0000);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule